// File: doc/BRIEF.md
# Serial Flash Boot Reader with Mode Recovery

This block is the boot-time SPI master that copies an image out of an external serial flash into on-chip memory. After a reset the flash can be left in a dual-bit or quad-bit transfer mode. A single-bit read command would not be understood in that state. So before reading, the block clocks four 32-bit words of all ones into the flash, each in its own chip-select frame, with every data line held high. Sixteen or more such clocks after a chip-select toggle return the flash to single-bit command mode.

After the recovery frames, the block opens one more frame. It sends the standard read command 0x03 with a 24-bit address of zero, then clocks in the number of bytes that was requested when `start` was pulsed. It writes each byte to a simple memory write port, starting at address 0, then releases chip select and pulses `done`. The write-protect and hold lines of the flash are driven high for the whole time, so six pins are under control. The serial clock is a parameterised division of the system clock.

Top module: `spi_boot_reader`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `spi_mosi` is 1, and `mem_we` and `done` are 0.
- R2: After `start`, the first four chip-select frames each carry exactly 32 rising SCK edges, and `spi_mosi` is 1 at every one of those edges.
- R3: `spi_wp_n` (IO2) and `spi_hold_n` (IO3) are 1 at all times.
- R4: Before each chip-select frame opens, `spi_cs_n` has been high for at least GAP_SCK SCK periods, that is 2*GAP_SCK*CLK_DIV_HALF system clocks (8 with the defaults).
- R5: SPI mode 0 is used. SCK idles low and toggles only inside a frame. MOSI changes only when SCK falls or when a frame opens. Data goes most significant bit first.
- R6: The fifth frame carries 0x03000000 as its first 32 bits, followed by exactly 8*N further SCK edges, where N is the `byte_count` latched at `start`.
- R7: The k-th byte received in the fifth frame (MISO sampled on rising SCK, first bit = bit 7) is written with `mem_we`=1 at `mem_addr`=k, for k = 0..N-1, in order.
- R8: `done` is a single-cycle pulse that comes after the last write, with `spi_cs_n` high. With N=0 there are no writes and the read frame carries only the 32 command bits.
- R9: Each SCK high phase lasts exactly CLK_DIV_HALF system clocks (CLK_DIV_HALF must be at least 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a boot sequence (accepted when idle) |
| byte_count | input | ADDR_W+1 | Number of bytes to copy, latched at start |
| spi_miso | input | 1 | Flash serial data out (IO1) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Flash serial data in (IO0) |
| spi_wp_n | output | 1 | IO2 / write protect, held high |
| spi_hold_n | output | 1 | IO3 / hold, held high |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
A behavioural flash model records every frame. It serves image bytes produced by a seeded function, so a swapped bit order, a lost byte or an off-by-one address shows up as a data mismatch in the scoreboard. The block is run with lengths of zero, one, an odd small count and the full memory depth. The zero and one-byte runs isolate the edge between the command and the data phase. The full-depth run exercises address wrap and the widest bit counter. Back-to-back runs with different seeds show that the state held between runs (recovery-word index, write address) restarts correctly.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_RECOVER,
    ST_CMD,
    ST_DATA,
    ST_END
  } boot_state_t;

  localparam int        WORD_BITS   = 32;
  localparam logic [31:0] RECOVER_WORD = 32'hFFFF_FFFF;
  localparam logic [31:0] READ_AT_ZERO = 32'h0300_0000;
endpackage

// File: rtl/spi_boot_clkdiv.sv
module spi_boot_clkdiv #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF + 1);

  generate
    if (HALF == 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !run)                 cnt <= '0;
        else if (cnt == CW'(HALF - 1))   cnt <= '0;
        else                             cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == CW'(HALF - 1));
    end
  endgenerate
endmodule

// File: rtl/spi_boot_rxbyte.sv
module spi_boot_rxbyte (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       sample,
  input  logic       din,
  output logic       byte_vld,
  output logic [7:0] byte_out
);
  logic [6:0] sh;
  logic [2:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh       <= '0;
      cnt      <= '0;
      byte_vld <= 1'b0;
      byte_out <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (sample) begin
        sh  <= {sh[5:0], din};
        cnt <= cnt + 1'b1;
        if (cnt == 3'd7) begin
          byte_vld <= 1'b1;
          byte_out <= {sh, din};
        end
      end
    end
  end
endmodule

// File: rtl/spi_boot_reader.sv
module spi_boot_reader
  import spi_boot_pkg::*;
#(
  parameter int CLK_DIV_HALF = 2,
  parameter int ADDR_W       = 10,
  parameter int GAP_SCK      = 2,
  parameter int RESET_WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W:0]   byte_count,
  input  logic              spi_miso,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  output logic              spi_wp_n,
  output logic              spi_hold_n,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              done
);
  localparam int LEN_W     = ADDR_W + 1;
  localparam int BIT_W     = ADDR_W + 4;
  localparam int GAP_TICKS = 2 * GAP_SCK;
  localparam int GAP_W     = $clog2(GAP_TICKS + 1);
  localparam int IDX_W     = $clog2(RESET_WORDS + 1);
  localparam int GAP_CYC   = GAP_TICKS * CLK_DIV_HALF;

  boot_state_t      st;
  logic [31:0]      tx_sh;
  logic [BIT_W-1:0] bit_cnt;
  logic [BIT_W-1:0] data_bits;
  logic [GAP_W-1:0] gap_cnt;
  logic [IDX_W-1:0] word_idx;
  logic [LEN_W-1:0] len_r;
  logic [LEN_W-1:0] wr_cnt;
  logic             sck_r, cs_n_r;
  logic             run, tick, last_bit;
  logic             rx_vld;
  logic [7:0]       rx_byte;

  assign run       = (st != ST_IDLE) && (st != ST_END);
  assign data_bits = {len_r, 3'b000};

  spi_boot_clkdiv #(.HALF(CLK_DIV_HALF)) u_div (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  spi_boot_rxbyte u_rx (
    .clk(clk), .rst(rst), .clr(st != ST_DATA),
    .sample((st == ST_DATA) && tick && !sck_r),
    .din(spi_miso), .byte_vld(rx_vld), .byte_out(rx_byte)
  );

  always_comb begin
    unique case (st)
      ST_RECOVER, ST_CMD: last_bit = (bit_cnt == BIT_W'(WORD_BITS - 1));
      ST_DATA:            last_bit = (bit_cnt == data_bits - 1'b1);
      default:            last_bit = 1'b0;
    endcase
  end

  // Sequencer: gap -> recovery words -> read command -> data bytes -> done
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      sck_r    <= 1'b0;
      cs_n_r   <= 1'b1;
      tx_sh    <= RECOVER_WORD;
      bit_cnt  <= '0;
      gap_cnt  <= '0;
      word_idx <= '0;
      len_r    <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          st       <= ST_GAP;
          gap_cnt  <= '0;
          word_idx <= '0;
          len_r    <= byte_count;
        end
        ST_GAP: if (tick) begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == GAP_W'(GAP_TICKS - 1)) begin
            cs_n_r  <= 1'b0;
            bit_cnt <= '0;
            if (word_idx < IDX_W'(RESET_WORDS)) begin
              st    <= ST_RECOVER;
              tx_sh <= RECOVER_WORD;
            end else begin
              st    <= ST_CMD;
              tx_sh <= READ_AT_ZERO;
            end
          end
        end
        ST_RECOVER, ST_CMD, ST_DATA: if (tick) begin
          if (!sck_r) begin
            sck_r <= 1'b1;
          end else begin
            sck_r   <= 1'b0;
            tx_sh   <= {tx_sh[30:0], 1'b1};
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) begin
              bit_cnt <= '0;
              if (st == ST_RECOVER) begin
                cs_n_r   <= 1'b1;
                st       <= ST_GAP;
                gap_cnt  <= '0;
                word_idx <= word_idx + 1'b1;
              end else if (st == ST_CMD && len_r != '0) begin
                st <= ST_DATA;
              end else begin
                cs_n_r <= 1'b1;
                st     <= ST_END;
              end
            end
          end
        end
        ST_END: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Memory write port, addresses counted from zero
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      mem_addr  <= '0;
      wr_cnt    <= '0;
    end else begin
      mem_we <= rx_vld;
      if (st == ST_IDLE && start) wr_cnt <= '0;
      if (rx_vld) begin
        mem_wdata <= rx_byte;
        mem_addr  <= wr_cnt[ADDR_W-1:0];
        wr_cnt    <= wr_cnt + 1'b1;
      end
    end
  end

  assign spi_sck    = sck_r;
  assign spi_cs_n   = cs_n_r;
  assign spi_mosi   = tx_sh[31];
  assign spi_wp_n   = 1'b1;
  assign spi_hold_n = 1'b1;

  // Checker state: length of the current chip-select high interval
  logic [15:0] cs_hi_len;
  always_ff @(posedge clk) begin
    if (rst || !cs_n_r)          cs_hi_len <= '0;
    else if (cs_hi_len != '1)    cs_hi_len <= cs_hi_len + 1'b1;
  end

  a_r4_cs_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_r) |-> ($past(cs_hi_len) >= 16'(GAP_CYC - 1)));

  a_r5_sck_in_frame: assert property (@(posedge clk) disable iff (rst)
    !$stable(sck_r) |-> !$past(cs_n_r));

  a_r5_mosi_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_sh[31]) |-> ($fell(sck_r) || $fell(cs_n_r)));

  a_r8_done_all_written: assert property (@(posedge clk) disable iff (rst)
    done |-> (wr_cnt == len_r) && cs_n_r && !mem_we);
endmodule

// File: tb/spi_boot_reader_test.sv
module spi_boot_reader_test;
  localparam int HALF = 2;
  localparam int AW   = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW:0]   byte_count = '0;
  logic          spi_miso = 1'b0;
  logic          spi_sck, spi_cs_n, spi_mosi, spi_wp_n, spi_hold_n;
  logic          mem_we, done;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  spi_boot_reader #(.CLK_DIV_HALF(HALF), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
    .spi_miso(spi_miso), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_wp_n(spi_wp_n), .spi_hold_n(spi_hold_n),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] img(input int seed, input int k);
    return 8'(k * 29 + seed) ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Scoreboard queue of expected {addr, data}
  logic [AW+7:0] exp_q[$];
  int  wr_seen;
  int  done_seen;

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      wr_seen++;
      if (exp_q.size() == 0) begin
        check(0, "R7", "unexpected write", longint'(mem_addr), 0);
      end else begin
        logic [AW+7:0] e;
        e = exp_q.pop_front();
        check({mem_addr, mem_wdata} == e, "R7", "write addr/data",
              longint'({mem_addr, mem_wdata}), longint'(e));
      end
    end
    if (!rst && done) done_seen++;
  end

  // Flash model and pin monitor
  int          cur_seed, cur_n;
  int          sess, nbits, cs_hi, sck_hi;
  logic [31:0] word;
  bit          allones, gap_bad, half_bad, io_bad;
  logic        prev_cs = 1'b1, prev_sck = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!(spi_wp_n && spi_hold_n)) io_bad = 1'b1;
      if (prev_cs && !spi_cs_n) begin
        if (cs_hi < 4 * HALF) gap_bad = 1'b1;
        sess++; nbits = 0; word = '0; allones = 1'b1;
      end
      cs_hi = spi_cs_n ? cs_hi + 1 : 0;
      if (!spi_cs_n && spi_sck && !prev_sck) begin
        if (nbits < 32) word = {word[30:0], spi_mosi};
        if (!spi_mosi) allones = 1'b0;
        nbits++;
      end
      if (spi_sck) sck_hi++;
      if (!spi_sck && prev_sck) begin
        if (sck_hi != HALF) half_bad = 1'b1;
        sck_hi = 0;
        if (!spi_cs_n && nbits >= 32) begin
          logic [7:0] b;
          b = img(cur_seed, (nbits - 32) / 8);
          spi_miso = b[7 - ((nbits - 32) % 8)];
        end
      end
      if (!prev_cs && spi_cs_n) begin
        if (sess <= 4)
          check(nbits == 32 && allones, "R2", "recovery frame bits/ones",
                nbits, 32);
        else if (sess == 5) begin
          check(word == 32'h0300_0000, "R6", "read command word", word,
                32'h0300_0000);
          check(nbits == 32 + 8 * cur_n, "R6", "read frame clock count",
                nbits, 32 + 8 * cur_n);
        end
      end
      prev_cs  = spi_cs_n;
      prev_sck = spi_sck;
    end
  end

  task automatic run_boot(input int n, input int seed);
    int t;
    for (int k = 0; k < n; k++) exp_q.push_back({AW'(k), img(seed, k)});
    cur_n = n; cur_seed = seed;
    sess = 0; wr_seen = 0; done_seen = 0;
    gap_bad = 0; half_bad = 0; io_bad = 0;
    @(negedge clk);
    byte_count = (AW+1)'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (done_seen == 0 && t < 20000) begin @(negedge clk); t++; end
    check(done_seen == 1, "R8", "done seen", done_seen, 1);
    check(spi_cs_n == 1'b1, "R8", "cs high at done", spi_cs_n, 1);
    @(negedge clk);
    check(done == 1'b0, "R8", "done single cycle", done, 0);
    repeat (4) @(negedge clk);
    check(done_seen == 1 && wr_seen == n, "R7", "write count", wr_seen, n);
    check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
    check(sess == 5, "R2", "frame count", sess, 5);
    check(!gap_bad, "R4", "cs high gap", gap_bad, 0);
    check(!half_bad && spi_sck == 1'b0, "R9", "sck half period / idle",
          half_bad, 0);
    check(!io_bad, "R3", "io2/io3 high", io_bad, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(spi_cs_n == 1 && spi_sck == 0 && spi_mosi == 1, "R1",
          "reset pins", {spi_cs_n, spi_sck, spi_mosi}, 3'b101);
    check(!mem_we && !done, "R1", "reset outputs", {mem_we, done}, 0);
    check(spi_wp_n && spi_hold_n, "R3", "io2/io3 after reset",
          {spi_wp_n, spi_hold_n}, 2'b11);
    run_boot(0, 3);    // R8 zero length
    run_boot(1, 17);   // R5 first data bit after command
    run_boot(5, 90);
    run_boot(64, 41);  // full depth
    run_boot(3, 200);  // restart with new seed
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule